// File: doc/BRIEF.md
# Shift Unit with Carry and Extend Flags

This block shifts a 32-bit operand left logically, right logically or right arithmetically by a count taken from a register. Along with the shifted word it returns the last bit pushed out as the carry, copies that carry into the extend flag, and derives negative and zero flags from the result. The overflow flag is always cleared. When the count is zero nothing moves, so the caller passes in the carry from the previous operation and the block returns it unchanged.

Operations enter through a valid/ready input channel and leave through a valid/ready output channel. An operation is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Its results appear on the outputs with `out_valid` high from the next edge on. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and `in_ready` stays low. An accepted result leaves on an edge where `out_valid` and `out_ready` are both high. A new operation may be accepted on that same edge.

Top module: `shf_carry_unit`

## Requirements
- R1: Only the low 6 bits of `in_count` count. Counts that are equal modulo 64 give identical outputs; for example, 65 behaves as 1 and 64 behaves as 0.
- R2: For an effective count of zero, the result equals the operand and the carry equals `in_carry`, for every shift kind.
- R3: A left shift by n in 1..31 gives operand << n. The carry is operand bit (32 - n).
- R4: A left shift by exactly 32 gives zero with the carry equal to operand bit 0. A left shift by 33..63 gives zero with a zero carry.
- R5: A logical right shift by n in 1..31 gives operand >> n with the carry equal to operand bit (n - 1). A shift by exactly 32 gives zero with the carry equal to bit 31. A shift by 33..63 gives zero with a zero carry.
- R6: An arithmetic right shift by n in 1..31 gives the sign-filled operand >> n, with the carry equal to operand bit (n - 1). A shift by 32..63 fills every result bit with the sign bit, and the carry equals the sign bit.
- R7: `out_extend` always equals `out_carry`.
- R8: `out_neg` equals result bit 31. `out_zero` is high exactly when the result is zero. `out_ovf` is always 0.
- R9: An operation accepted on one edge is presented with `out_valid` high after that edge.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all outputs hold their values.
- R11: The kind code `in_kind` is decoded as follows: 00 is a logical left shift, 01 is a logical right shift, and 10 and 11 are both arithmetic right shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_value | input | 32 | Operand to shift |
| in_count | input | 32 | Shift count register; low 6 bits used |
| in_kind | input | 2 | Shift kind code |
| in_carry | input | 1 | Carry left by the previous operation |
| out_valid | output | 1 | Result held on the outputs |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Shifted word |
| out_carry | output | 1 | Last bit shifted out |
| out_extend | output | 1 | Extend flag, copy of the carry |
| out_neg | output | 1 | Result sign |
| out_zero | output | 1 | Result is zero |
| out_ovf | output | 1 | Overflow flag, always 0 |

## Verification
The bench builds the block with its default parameters: a 32-bit data width and a 6-bit count field. With these values the directed and random counts cover every count class: zero, the partial range, exactly the width, and beyond the width. Counts above 63 in the full count register test the modulo-64 wraparound. A stalled output channel, with a second operation waiting behind it, tests the hold and back-pressure rules.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    KIND_LSL  = 2'b00,
    KIND_LSR  = 2'b01,
    KIND_ASR  = 2'b10,
    KIND_ASR2 = 2'b11
  } shf_kind_e;

  typedef enum logic [1:0] {
    CNT_NONE    = 2'b00,
    CNT_PARTIAL = 2'b01,
    CNT_FULL    = 2'b10,
    CNT_BEYOND  = 2'b11
  } shf_cnt_class_e;

endpackage

// File: rtl/shf_count_class.sv
module shf_count_class
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic [DATA_W-1:0] count_raw,
  output logic [CNT_W-1:0]  amount,
  output shf_cnt_class_e    cls
);
  localparam logic [CNT_W:0] WIDTH_C = (CNT_W+1)'(DATA_W);

  logic [CNT_W:0] amt_ext;

  // the count wraps modulo 2**CNT_W
  assign amount  = count_raw[CNT_W-1:0];
  assign amt_ext = {1'b0, amount};

  always_comb begin
    if (amt_ext == '0)            cls = CNT_NONE;
    else if (amt_ext < WIDTH_C)   cls = CNT_PARTIAL;
    else if (amt_ext == WIDTH_C)  cls = CNT_FULL;
    else                          cls = CNT_BEYOND;
  end
endmodule

// File: rtl/shf_datapath.sv
module shf_datapath
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic [DATA_W-1:0] value,
  input  logic [CNT_W-1:0]  amount,
  input  logic [1:0]        kind,
  input  shf_cnt_class_e    cls,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry,
  output logic              neg,
  output logic              zero
);
  // one guard bit beside the word catches the last bit pushed out
  logic [DATA_W:0]        left_w;
  logic [DATA_W:0]        right_w;
  logic signed [DATA_W:0] arith_w;

  assign left_w  = {1'b0, value} << amount;
  assign right_w = {value, 1'b0} >> amount;
  assign arith_w = $signed({value, 1'b0}) >>> amount;

  always_comb begin
    if (cls == CNT_NONE) begin
      result = value;
      carry  = carry_in;
    end else if (kind[1]) begin
      result = arith_w[DATA_W:1];
      carry  = arith_w[0];
    end else if (kind[0]) begin
      result = right_w[DATA_W:1];
      carry  = right_w[0];
    end else begin
      result = left_w[DATA_W-1:0];
      carry  = left_w[DATA_W];
    end
  end

  assign neg  = result[DATA_W-1];
  assign zero = (result == '0);
endmodule

// File: rtl/shf_out_slice.sv
module shf_out_slice #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] d_result,
  input  logic              d_carry,
  input  logic              d_neg,
  input  logic              d_zero,
  output logic              q_valid,
  input  logic              q_ready,
  output logic [DATA_W-1:0] q_result,
  output logic              q_carry,
  output logic              q_extend,
  output logic              q_neg,
  output logic              q_zero
);
  logic take;

  assign in_ready = !q_valid || q_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_result <= '0;
      q_carry  <= 1'b0;
      q_extend <= 1'b0;
      q_neg    <= 1'b0;
      q_zero   <= 1'b0;
    end else begin
      if (take) begin
        q_valid  <= 1'b1;
        q_result <= d_result;
        q_carry  <= d_carry;
        q_extend <= d_carry;
        q_neg    <= d_neg;
        q_zero   <= d_zero;
      end else if (q_ready) begin
        q_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/shf_carry_unit.sv
module shf_carry_unit
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_value,
  input  logic [DATA_W-1:0] in_count,
  input  logic [1:0]        in_kind,
  input  logic              in_carry,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_carry,
  output logic              out_extend,
  output logic              out_neg,
  output logic              out_zero,
  output logic              out_ovf
);
  logic [CNT_W-1:0]  amount;
  shf_cnt_class_e    cls;
  logic [DATA_W-1:0] dp_result;
  logic              dp_carry;
  logic              dp_neg;
  logic              dp_zero;
  logic              accept;

  shf_count_class #(.DATA_W(DATA_W), .CNT_W(CNT_W)) cnt_u (
    .count_raw (in_count),
    .amount    (amount),
    .cls       (cls)
  );

  shf_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dp_u (
    .value    (in_value),
    .amount   (amount),
    .kind     (in_kind),
    .cls      (cls),
    .carry_in (in_carry),
    .result   (dp_result),
    .carry    (dp_carry),
    .neg      (dp_neg),
    .zero     (dp_zero)
  );

  shf_out_slice #(.DATA_W(DATA_W)) out_u (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .d_result (dp_result),
    .d_carry  (dp_carry),
    .d_neg    (dp_neg),
    .d_zero   (dp_zero),
    .q_valid  (out_valid),
    .q_ready  (out_ready),
    .q_result (out_result),
    .q_carry  (out_carry),
    .q_extend (out_extend),
    .q_neg    (out_neg),
    .q_zero   (out_zero)
  );

  assign out_ovf = 1'b0;
  assign accept  = in_valid && in_ready;

  assert_zero_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cls == CNT_NONE) |=>
      (out_result == $past(in_value) && out_carry == $past(in_carry)));

  assert_left_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind == 2'b00 && cls == CNT_FULL) |=>
      (out_result == '0 && out_carry == $past(in_value[0])));

  assert_logic_beyond_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_kind[1] && cls == CNT_BEYOND) |=>
      (out_result == '0 && !out_carry));

  assert_sign_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind[1] && (cls == CNT_FULL || cls == CNT_BEYOND)) |=>
      (out_result == {DATA_W{$past(in_value[DATA_W-1])}} &&
       out_carry == $past(in_value[DATA_W-1])));

  assert_extend_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_extend == out_carry));

  assert_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_zero == (out_result == '0) &&
                   out_neg == out_result[DATA_W-1]));

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_carry) &&
       $stable(out_neg) && $stable(out_zero)));

  assert_stall_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/shf_carry_unit_tb.sv
module shf_carry_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_value = '0;
  logic [31:0] in_count = '0;
  logic [1:0]  in_kind = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_carry, out_extend, out_neg, out_zero, out_ovf;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shf_carry_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_count(in_count), .in_kind(in_kind),
    .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_carry(out_carry),
    .out_extend(out_extend), .out_neg(out_neg), .out_zero(out_zero),
    .out_ovf(out_ovf)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // bit-at-a-time reference model
  function automatic logic [32:0] ref_shift(input logic [31:0] v, input logic [31:0] c,
                                            input logic [1:0] k, input logic ci);
    logic [31:0] r = v;
    logic cy = ci;
    int n = int'(c[5:0]);
    for (int i = 0; i < n; i++) begin
      if (k == 2'b00) begin cy = r[31]; r = {r[30:0], 1'b0}; end
      else if (k == 2'b01) begin cy = r[0]; r = {1'b0, r[31:1]}; end
      else begin cy = r[0]; r = {r[31], r[31:1]}; end
    end
    return {cy, r};
  endfunction

  function automatic string tag_of(input logic [31:0] c, input logic [1:0] k);
    if (c[5:0] == 0) return "R2";
    if (k == 2'b00) return (c[5:0] < 32) ? "R3" : "R4";
    if (k == 2'b01) return "R5";
    return "R6";
  endfunction

  task automatic run_op(input logic [31:0] v, input logic [31:0] c,
                        input logic [1:0] k, input logic ci);
    logic [32:0] e;
    string t;
    e = ref_shift(v, c, k, ci);
    t = tag_of(c, k);
    @(negedge clk);
    in_valid = 1'b1; in_value = v; in_count = c; in_kind = k; in_carry = ci;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 out_valid", {31'd0, out_valid}, 32'd1);
    chk({t, " result"}, out_result, e[31:0]);
    chk({t, " carry"}, {31'd0, out_carry}, {31'd0, e[32]});
    chk("R7 extend", {31'd0, out_extend}, {31'd0, e[32]});
    chk("R8 flags", {29'd0, out_neg, out_zero, out_ovf},
        {29'd0, e[31], (e[31:0] == 32'd0), 1'b0});
  endtask

  initial begin
    logic [31:0] keep_res;
    logic [32:0] e;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R10 reset in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    // R2: zero count keeps carry, both polarities
    run_op(32'hDEAD_BEEF, 32'd0, 2'b00, 1'b1);
    run_op(32'h8000_0001, 32'd0, 2'b10, 1'b0);
    // R3 / R4 left corners
    run_op(32'h4000_0001, 32'd1, 2'b00, 1'b1);
    run_op(32'h0000_0001, 32'd31, 2'b00, 1'b0);
    run_op(32'h0000_0001, 32'd32, 2'b00, 1'b0);
    run_op(32'hFFFF_FFFF, 32'd33, 2'b00, 1'b1);
    // R5 logical right corners
    run_op(32'h0000_0003, 32'd1, 2'b01, 1'b0);
    run_op(32'h8000_0000, 32'd32, 2'b01, 1'b0);
    run_op(32'hFFFF_FFFF, 32'd63, 2'b01, 1'b1);
    // R6 arithmetic corners
    run_op(32'h8000_0010, 32'd4, 2'b10, 1'b0);
    run_op(32'h8000_0000, 32'd32, 2'b10, 1'b0);
    run_op(32'h7FFF_FFFF, 32'd40, 2'b10, 1'b1);
    // R11: code 11 is arithmetic right
    run_op(32'hF000_0000, 32'd8, 2'b11, 1'b0);
    e = ref_shift(32'hF000_0000, 32'd8, 2'b10, 1'b0);
    chk("R11 kind 11 sign fill", out_result, e[31:0]);
    // R1: count wraps modulo 64
    run_op(32'h1234_5679, 32'd65, 2'b01, 1'b0);
    chk("R1 count 65 as 1", out_result, 32'h091A_2B3C);
    run_op(32'h1234_5678, 32'h0000_0140, 2'b00, 1'b1);
    chk("R1 count 0x140 as 0", {out_carry, out_result}, {1'b1, 32'h1234_5678});

    // R10: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_value = 32'h0000_00F0; in_count = 32'd4; in_kind = 2'b01; in_carry = 1'b0;
    @(negedge clk);
    keep_res = out_result;
    chk("R10 first result", out_result, 32'h0000_000F);
    in_value = 32'h0000_0001; in_count = 32'd31; in_kind = 2'b00;
    chk("R10 in_ready low", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    chk("R10 held result", out_result, keep_res);
    chk("R10 held valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 next result", out_result, 32'h8000_0000);
    @(negedge clk);
    chk("R10 drained", {31'd0, out_valid}, 32'd0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] v, c;
      logic [1:0] k;
      v = $urandom();
      c = $urandom();
      if (i % 4 == 0) c = {c[31:6], 6'd32};
      k = 2'($urandom());
      run_op(v, c, k, 1'($urandom()));
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule